// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a simple 32-bit processor front end. On every rising clock edge it replaces the counter with the address of the next instruction to fetch. That address is derived from the instruction word fetched at the current counter value and from a taken/not-taken flag. The flag comes from a comparator outside the block.

The block reads the 6-bit opcode in bits 31:26 and assigns the instruction to one of three flow states. The states are named FLOW_SEQ, FLOW_BRANCH and FLOW_JUMP, and the current state is reported on `flow_class`.

- **FLOW_SEQ:** the counter steps by one word.
- **FLOW_BRANCH:** the counter moves to a PC-relative target when the flag is high, and otherwise steps by one word.
- **FLOW_JUMP:** the counter moves to a pseudodirect target. That target is built from the 26-bit word index of the instruction placed under the top bits of the incremented counter.

Each clock, the transition out of the current state follows from the instruction. The transitions are named STEP, TAKE and SPLICE. A synchronous reset forces the counter to zero.

Top module: `next_pc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0x00000000 on that edge, whatever `instr` and `cond_met` hold.
- R2: When bits 31:26 of `instr` hold neither 0x04 nor 0x02 (for example 0x23, 0x2B, 0x08), then:
  - `flow_class` reads 2'd0 (FLOW_SEQ).
  - `pc` becomes `pc`+4 at the next edge (transition STEP).
  - The register fields (bits 25:21, 20:16) and all other bits have no effect on the result.
- R3: With opcode 0x04, `flow_class` reads 2'd1 (FLOW_BRANCH). If `cond_met` is low, `pc` becomes `pc`+4.
- R4: With opcode 0x04 and `cond_met` high, `pc` becomes (`pc`+4) + (sign-extended bits 15:0 shifted left by two), which is transition TAKE.
- R5: A negative branch offset produces a backward target. An offset of 0xFFFF (−1) leaves `pc` unchanged.
- R6: With opcode 0x02, `flow_class` reads 2'd2 (FLOW_JUMP). `pc` becomes {(`pc`+4)[31:28], `instr`[25:0], 2'b00}, which is transition SPLICE. The upper four bits come from `pc`+4, so a jump at 0x0FFFFFFC lands in the 0x1 region.
- R7: `cond_met` has no effect unless the opcode is 0x04.
- R8: `flow_class` is combinational in the present `instr`, and the two low bits of `pc` are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction fetched at the current `pc` |
| cond_met | input | 1 | Branch condition from the external comparator |
| pc | output | 32 | Current program counter |
| flow_class | output | 2 | Flow state of `instr`: 0 sequential, 1 branch, 2 jump |

## Verification
The in-RTL properties check the following on every cycle:
- The step-by-four on sequential and untaken-branch cycles.
- The preservation of the upper counter bits taken from the incremented value on jumps.
- Word alignment of the counter.
- The reset value.

Only the bench scenarios can show that the exact taken-branch arithmetic is correct. Those scenarios cover forward and backward offsets, the self-loop offset −1, the jump that crosses into the next 256 MiB region, and that register fields and a stray condition flag are ignored.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int XLEN   = 32;
    localparam int OP_W   = 6;
    localparam int IMM_W  = 16;
    localparam int JIDX_W = 26;

    localparam logic [OP_W-1:0] OP_BRANCH = 6'h04;
    localparam logic [OP_W-1:0] OP_JUMP   = 6'h02;

    typedef enum logic [1:0] {
        FLOW_SEQ    = 2'd0,
        FLOW_BRANCH = 2'd1,
        FLOW_JUMP   = 2'd2
    } flow_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output flow_e           flow
);
    always_comb begin
        unique case (opcode)
            OP_BRANCH: flow = FLOW_BRANCH;
            OP_JUMP:   flow = FLOW_JUMP;
            default:   flow = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int IW = IMM_W,
    parameter int JW = JIDX_W
) (
    input  logic [AW-1:0] pc_now,
    input  logic [JW-1:0] low_field,
    output logic [AW-1:0] seq_tgt,
    output logic [AW-1:0] br_tgt,
    output logic [AW-1:0] jmp_tgt
);
    localparam int EXT_W = AW - IW - 2;
    localparam int TOP_W = AW - JW - 2;

    logic [IW-1:0] offset;
    logic [AW-1:0] byte_off;

    assign offset   = low_field[IW-1:0];
    assign byte_off = {{EXT_W{offset[IW-1]}}, offset, 2'b00};
    assign seq_tgt  = pc_now + AW'(4);
    assign br_tgt   = seq_tgt + byte_off;
    assign jmp_tgt  = {seq_tgt[AW-1 -: TOP_W], low_field, 2'b00};
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
    import npc_pkg::*;
#(
    parameter int AW = XLEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] instr,
    input  logic          cond_met,
    output logic [AW-1:0] pc,
    output logic [1:0]    flow_class
);
    localparam int TOP_W = AW - JIDX_W - 2;

    flow_e         flow;
    logic [AW-1:0] seq_tgt, br_tgt, jmp_tgt, pc_next;

    npc_decode u_decode (
        .opcode (instr[AW-1 -: OP_W]),
        .flow   (flow)
    );

    npc_target #(.AW(AW), .IW(IMM_W), .JW(JIDX_W)) u_target (
        .pc_now    (pc),
        .low_field (instr[JIDX_W-1:0]),
        .seq_tgt   (seq_tgt),
        .br_tgt    (br_tgt),
        .jmp_tgt   (jmp_tgt)
    );

    // Transition selection: STEP, TAKE or SPLICE
    always_comb begin
        unique case (flow)
            FLOW_BRANCH: pc_next = cond_met ? br_tgt : seq_tgt;
            FLOW_JUMP:   pc_next = jmp_tgt;
            default:     pc_next = seq_tgt;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end

    // Output process
    always_comb flow_class = flow;

    // R1: reset value
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> pc == '0);

    // R2: sequential step
    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (instr[AW-1 -: OP_W] != OP_BRANCH && instr[AW-1 -: OP_W] != OP_JUMP)
        |=> pc == $past(pc) + AW'(4));

    // R3: untaken branch
    p_br_untaken_r3: assert property (@(posedge clk) disable iff (rst)
        (instr[AW-1 -: OP_W] == OP_BRANCH && !cond_met)
        |=> pc == $past(pc) + AW'(4));

    // R6: jump keeps region of pc+4
    p_jump_region_r6: assert property (@(posedge clk) disable iff (rst)
        (instr[AW-1 -: OP_W] == OP_JUMP)
        |=> pc[AW-1 -: TOP_W] == $past(pc + AW'(4)) >> (AW - TOP_W));

    // R8: word alignment
    p_aligned_r8: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);
endmodule

// File: tb/tb_next_pc_unit.sv
module tb_next_pc_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] instr;
    logic        cond_met;
    logic [31:0] pc;
    logic [1:0]  flow_class;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] exp_pc;

    always #4 clk = ~clk;

    next_pc_unit dut (
        .clk(clk), .rst(rst), .instr(instr), .cond_met(cond_met),
        .pc(pc), .flow_class(flow_class)
    );

    function automatic logic [31:0] model_next(logic [31:0] p, logic [31:0] i, logic c);
        logic [31:0] s;
        s = p + 32'd4;
        case (i[31:26])
            6'h04:   return c ? s + {{14{i[15]}}, i[15:0], 2'b00} : s;
            6'h02:   return {s[31:28], i[25:0], 2'b00};
            default: return s;
        endcase
    endfunction

    function automatic logic [1:0] model_class(logic [31:0] i);
        case (i[31:26])
            6'h04:   return 2'd1;
            6'h02:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at negedge, check class, then check pc at the following negedge
    task automatic step(logic [31:0] i, logic c, string req);
        instr = i; cond_met = c;
        #1;
        check({req, " class"}, {30'd0, flow_class}, {30'd0, model_class(i)});
        exp_pc = model_next(pc, i, c);
        @(negedge clk);
        check({req, " pc"}, pc, exp_pc);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset", pc, 32'h0);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; instr = 32'h0; cond_met = 1'b0;
        @(negedge clk);
        @(negedge clk);
        do_reset();

        // R2: non-control opcodes, fields and flag ignored (R7)
        step({6'h23, 5'd18, 5'd17, 16'd100}, 1'b1, "R2 R7 load");
        step({6'h2B, 5'd18, 5'd17, 16'd100}, 1'b0, "R2 store");
        step({6'h08, 5'd31, 5'd31, 16'hFFFF}, 1'b1, "R2 R7 addi");
        // R3: untaken branch
        step({6'h04, 5'd1, 5'd2, 16'h0040}, 1'b0, "R3 untaken");
        // R4: forward taken
        step({6'h04, 5'd1, 5'd2, 16'h0010}, 1'b1, "R4 forward");
        // R5: backward and self-loop
        step({6'h04, 5'd3, 5'd4, 16'hFFF8}, 1'b1, "R5 backward");
        step({6'h04, 5'd3, 5'd4, 16'hFFFF}, 1'b1, "R5 self");
        check("R5 self unchanged", pc, exp_pc);
        // R6: jump field 25, flag ignored (R7)
        step({6'h02, 26'd25}, 1'b1, "R6 R7 jump25");
        check("R6 target 0x64", pc, 32'h0000_0064);
        // R6: region crossing
        step({6'h02, 26'h3FF_FFFF}, 1'b0, "R6 jump top");
        check("R6 at 0x0FFFFFFC", pc, 32'h0FFF_FFFC);
        step({6'h02, 26'd25}, 1'b0, "R6 cross");
        check("R6 upper from pc+4", pc, 32'h1000_0064);
        // R1: reset mid-run
        do_reset();

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            logic [5:0]  op;
            r = $urandom;
            case ($urandom % 6)
                0: op = 6'h23;
                1: op = 6'h2B;
                2: op = 6'h08;
                3: op = 6'h04;
                4: op = 6'h02;
                default: op = 6'($urandom);
            endcase
            step({op, r[25:0]}, 1'($urandom), "R2 R3 R4 R6 R8 random");
            check("R8 aligned", {30'd0, pc[1:0]}, 32'd0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule